// File: doc/BRIEF.md
# Software Trace Stimulus Packetizer

This block collects instrumentation writes from software and turns them into a byte-serial trace stream. Software writes a word, half-word or byte to one of a bank of stimulus ports. Each port has its own enable bit. A single formatter drains the ports and emits self-describing packets that a downstream trace sink can capture: source packets, overflow markers and timestamp packets. Timestamp packets follow every write to a dedicated timestamp port.

Each stimulus port owns a small circular queue. When the queue addressed by a write is full, the write interface stalls the writer. A writer that cannot stall can force the write through; the data is then dropped and an overflow marker is queued in its place. The output is a valid/ready byte stream. Once a byte is offered it is held, with its value unchanged, until the sink accepts it, and a sink holding ready low stops the stream without losing data. A global trace enable gates all packet generation. A 64-bit timestamp counter runs off a programmable prescaler.

Top module: `stim_trace_top`

## Requirements
- R1: After reset, out_valid is low, all port queues are empty, wr_ready is high, and the timestamp counter is zero.
- R2: A write to a port whose port_en bit is 0 is accepted without stalling and is discarded; no packet results.
- R3: A source packet is two header bytes followed by the payload. Header byte 0 is {port[4:0], 1'b0, size}. Header byte 1 is port >> 5.
- R4: Size codes are 01 for 1 byte, 10 for 2 bytes and 11 for 4 bytes of wr_data, sent least significant byte first. A write with size code 00 is accepted and discarded.
- R5: Each port queue holds 8 writes. While the output is stalled, 8 writes to one port are accepted, and wr_ready is low for a 9th unforced write to that port.
- R6: A write with wr_force high is always accepted. If the target queue is full, the data is dropped and a single overflow byte 0x70 is emitted, one marker for any number of losses before it is sent.
- R7: A pending overflow marker is sent before the next source packet.
- R8: Non-empty port queues are drained lowest port number first.
- R9: A source packet from port 31 is followed at once by a timestamp packet: byte 0x07, then 8 bytes of the counter value, least significant first. The value is the one the counter held at the clock edge that accepted the write.
- R10: The timestamp counter advances by one every ts_div+1 clock cycles.
- R11: While trace_en is 0, writes are accepted and discarded and no new packet starts.
- R12: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R13: Writes to one port are emitted in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Global trace enable |
| port_en | input | NUM_PORTS | Per-port write enable bits |
| ts_div | input | PRE_W | Timestamp prescaler: counter steps every ts_div+1 cycles |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted on this cycle when valid |
| wr_addr | input | PW | Target stimulus port number |
| wr_size | input | 2 | Size code: 01 byte, 10 half-word, 11 word, 00 discarded |
| wr_data | input | 32 | Write data, low bytes used for narrow sizes |
| wr_force | input | 1 | Accept even when the queue is full (data is lost, overflow marked) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output trace byte |

## Verification
Every cycle, the assertions check the stream holding rule and that disabled ports and forced writes never stall the writer. They also check that no packet starts while tracing is off and that the block is idle right after reset. The bench's scenarios show the rest: header and payload encoding for each size, the exact queue depth at which the writer stalls, and that the overflow marker overtakes queued data. They also cover lowest-port-first draining with per-port ordering and the captured timestamp values under the prescaler.

// File: rtl/stim_trace_pkg.sv
package stim_trace_pkg;
  localparam logic [7:0] OVF_CODE = 8'h70;
  localparam logic [7:0] TS_CODE  = 8'h07;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_B1   = 2'b01,
    SZ_B2   = 2'b10,
    SZ_B4   = 2'b11
  } sz_e;

  typedef enum logic [2:0] {
    F_IDLE, F_OVF, F_HDR0, F_HDR1, F_PAY, F_TSH, F_TSV
  } fmt_e;

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] data;
  } stim_ent_t;

  function automatic logic [2:0] sz_bytes(input logic [1:0] s);
    case (s)
      SZ_B1:   return 3'd1;
      SZ_B2:   return 3'd2;
      SZ_B4:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/stim_fifo.sv
module stim_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/stim_pick.sv
module stim_pick #(
  parameter int N  = 256,
  parameter int IW = 8
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/stim_tsgen.sv
module stim_tsgen #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div,
  output logic [63:0]      stamp
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      stamp <= '0;
    end else if (pre_q >= div) begin
      pre_q <= '0;
      stamp <= stamp + 64'd1;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/stim_fmt.sv
module stim_fmt
  import stim_trace_pkg::*;
#(
  parameter int PW      = 8,
  parameter int TS_PORT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic          ovf_pend,
  input  logic          req_any,
  input  logic [PW-1:0] req_port,
  input  stim_ent_t     req_ent,
  input  logic [63:0]   req_ts,
  input  logic          out_ready,
  output logic          take_src,
  output logic          take_ovf,
  output logic          out_valid,
  output logic [7:0]    out_data
);
  fmt_e          st;
  logic [PW-1:0] port_q;
  logic [1:0]    size_q;
  logic [31:0]   data_q;
  logic [2:0]    left_q;
  logic [63:0]   ts_q;
  logic [3:0]    tsleft_q;
  logic [12:0]   pwide;

  assign pwide = 13'(port_q);

  always_comb begin
    take_ovf  = (st == F_IDLE) && trace_en && ovf_pend;
    take_src  = (st == F_IDLE) && trace_en && !ovf_pend && req_any;
    out_valid = (st != F_IDLE);
    case (st)
      F_OVF:   out_data = OVF_CODE;
      F_HDR0:  out_data = {pwide[4:0], 1'b0, size_q};
      F_HDR1:  out_data = pwide[12:5];
      F_PAY:   out_data = data_q[7:0];
      F_TSH:   out_data = TS_CODE;
      F_TSV:   out_data = ts_q[7:0];
      default: out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      port_q   <= '0;
      size_q   <= '0;
      data_q   <= '0;
      left_q   <= '0;
      ts_q     <= '0;
      tsleft_q <= '0;
    end else begin
      case (st)
        F_IDLE: begin
          if (take_ovf) begin
            st <= F_OVF;
          end else if (take_src) begin
            port_q <= req_port;
            size_q <= req_ent.size;
            data_q <= req_ent.data;
            left_q <= sz_bytes(req_ent.size);
            ts_q   <= req_ts;
            st     <= F_HDR0;
          end
        end
        F_OVF:  if (out_ready) st <= F_IDLE;
        F_HDR0: if (out_ready) st <= F_HDR1;
        F_HDR1: if (out_ready) st <= F_PAY;
        F_PAY: begin
          if (out_ready) begin
            data_q <= {8'h00, data_q[31:8]};
            left_q <= left_q - 3'd1;
            if (left_q == 3'd1)
              st <= (port_q == PW'(TS_PORT)) ? F_TSH : F_IDLE;
          end
        end
        F_TSH: begin
          if (out_ready) begin
            tsleft_q <= 4'd8;
            st       <= F_TSV;
          end
        end
        F_TSV: begin
          if (out_ready) begin
            ts_q     <= {8'h00, ts_q[63:8]};
            tsleft_q <= tsleft_q - 4'd1;
            if (tsleft_q == 4'd1) st <= F_IDLE;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stim_trace_top.sv
module stim_trace_top
  import stim_trace_pkg::*;
#(
  parameter int NUM_PORTS = 256,
  parameter int DEPTH     = 8,
  parameter int TS_PORT   = 31,
  parameter int PRE_W     = 16,
  localparam int PW       = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trace_en,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [PRE_W-1:0]     ts_div,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [PW-1:0]        wr_addr,
  input  logic [1:0]           wr_size,
  input  logic [31:0]          wr_data,
  input  logic                 wr_force,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data
);
  localparam int EW = $bits(stim_ent_t);

  logic [NUM_PORTS-1:0] q_full, q_empty, full_eff, req, push_vec, pop_vec;
  stim_ent_t            q_dout [NUM_PORTS];
  stim_ent_t            wr_ent;
  logic [PW-1:0]        sel_idx;
  logic                 sel_any;
  logic                 take_src, take_ovf;
  logic                 wr_live, tgt_full, accept, do_push, do_drop;
  logic                 ovf_q;
  logic [63:0]          stamp, ts_head;
  logic                 ts_full, ts_empty, ts_push, ts_pop;

  assign wr_ent   = '{size: wr_size, data: wr_data};
  assign wr_live  = trace_en && port_en[wr_addr] && (wr_size != SZ_NONE);
  assign tgt_full = full_eff[wr_addr];
  assign wr_ready = !(wr_live && tgt_full) || wr_force;
  assign accept   = wr_valid && wr_ready;
  assign do_push  = accept && wr_live && !tgt_full;
  assign do_drop  = accept && wr_live && tgt_full;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign push_vec[p] = do_push && (wr_addr == PW'(p));
    assign pop_vec[p]  = take_src && (sel_idx == PW'(p));

    stim_fifo #(.W(EW), .DEPTH(DEPTH)) q_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[p]),
      .din   (wr_ent),
      .pop   (pop_vec[p]),
      .dout  (q_dout[p]),
      .empty (q_empty[p]),
      .full  (q_full[p])
    );

    if (p == TS_PORT) begin : g_ts
      assign req[p]      = !q_empty[p] && !ts_empty;
      assign full_eff[p] = q_full[p] || ts_full;
    end else begin : g_plain
      assign req[p]      = !q_empty[p];
      assign full_eff[p] = q_full[p];
    end
  end

  assign ts_push = do_push && (wr_addr == PW'(TS_PORT));
  assign ts_pop  = take_src && (sel_idx == PW'(TS_PORT));

  stim_fifo #(.W(64), .DEPTH(DEPTH)) ts_q_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ts_push),
    .din   (stamp),
    .pop   (ts_pop),
    .dout  (ts_head),
    .empty (ts_empty),
    .full  (ts_full)
  );

  stim_tsgen #(.PRE_W(PRE_W)) tsgen_i (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (ts_div),
    .stamp (stamp)
  );

  stim_pick #(.N(NUM_PORTS), .IW(PW)) pick_i (
    .req (req),
    .idx (sel_idx),
    .any (sel_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= (ovf_q && !take_ovf) || do_drop;
  end

  stim_fmt #(.PW(PW), .TS_PORT(TS_PORT)) fmt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_en  (trace_en),
    .ovf_pend  (ovf_q),
    .req_any   (sel_any),
    .req_port  (sel_idx),
    .req_ent   (q_dout[sel_idx]),
    .req_ts    (ts_head),
    .out_ready (out_ready),
    .take_src  (take_src),
    .take_ovf  (take_ovf),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/stim_trace_chk.sv
module stim_trace_chk #(
  parameter int NUM_PORTS = 256,
  parameter int PW        = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trace_en,
  input logic [NUM_PORTS-1:0] port_en,
  input logic                 wr_valid,
  input logic                 wr_ready,
  input logic [PW-1:0]        wr_addr,
  input logic                 wr_force,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [7:0]           out_data
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

  a_r2_disabled_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !port_en[wr_addr]) |-> wr_ready);

  a_r6_force_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_force) |-> wr_ready);

  a_r11_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !out_valid) |=> !out_valid);

  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind stim_trace_top stim_trace_chk #(.NUM_PORTS(NUM_PORTS), .PW(PW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .trace_en  (trace_en),
  .port_en   (port_en),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_force  (wr_force),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/stim_trace_top_tb_top.sv
module stim_trace_top_tb_top;
  localparam int NP    = 256;
  localparam int PW    = 8;
  localparam int PRE_W = 16;
  localparam int DIV   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trace_en = 1'b0;
  logic [NP-1:0] port_en = '0;
  logic [PRE_W-1:0] ts_div = PRE_W'(DIV);
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [PW-1:0] wr_addr = '0;
  logic [1:0]    wr_size = '0;
  logic [31:0]   wr_data = '0;
  logic          wr_force = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;

  stim_trace_top dut_i (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .port_en(port_en),
    .ts_div(ts_div), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .wr_force(wr_force), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #10 clk = ~clk;

  int edge_cnt = 0;
  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_b[$];
  string      exp_r[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic void push_exp(input logic [7:0] b, input string r);
    exp_b.push_back(b);
    exp_r.push_back(r);
  endfunction

  function automatic void exp_src(input int port, input int size,
                                  input logic [31:0] data, input longint ts,
                                  input string r);
    int n;
    n = (size == 1) ? 1 : (size == 2) ? 2 : 4;
    push_exp(8'(((port & 31) << 3) | size), r);
    push_exp(8'(port >> 5), r);
    for (int i = 0; i < n; i++) push_exp(data[8*i +: 8], r);
    if (port == 31) begin
      push_exp(8'h07, "R9");
      for (int i = 0; i < 8; i++) push_exp(8'(ts >> (8 * i)), "R9");
    end
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_b.size() == 0) begin
          chk(1'b0, "R2", "unexpected output byte", out_data, 0);
        end else begin
          logic [7:0] e;
          string r;
          e = exp_b.pop_front();
          r = exp_r.pop_front();
          chk(out_data == e, r, "stream byte", out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic try_write(input int port, input logic [31:0] data,
                           input int size, input bit force_w,
                           output bit acc, output longint ts);
    @(negedge clk);
    wr_addr  = PW'(port);
    wr_data  = data;
    wr_size  = 2'(size);
    wr_force = force_w;
    wr_valid = 1'b1;
    #1;
    acc = wr_ready;
    ts  = longint'(edge_cnt / (DIV + 1));
    @(negedge clk);
    wr_valid = 1'b0;
    wr_force = 1'b0;
  endtask

  task automatic do_write(input int port, input logic [31:0] data,
                          input int size, output longint ts);
    bit acc;
    acc = 1'b0;
    while (!acc) try_write(port, data, size, 1'b0, acc, ts);
  endtask

  task automatic wait_drain(input string r);
    int t;
    t = 0;
    #3;
    while ((exp_b.size() != 0 || out_valid) && t < 400) begin
      @(negedge clk);
      #3;
      t++;
    end
    chk(exp_b.size() == 0, r, "bytes still expected", exp_b.size(), 0);
  endtask

  task automatic quiet(input int n, input string r);
    int seen;
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      #2;
      if (out_valid) seen++;
    end
    chk(seen == 0, r, "cycles with out_valid", seen, 0);
  endtask

  initial begin
    longint ts, ts1;
    bit acc;
    logic [7:0] prev_d;
    bit prev_stall;

    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);

    port_en = '1;
    port_en[6] = 1'b0;
    trace_en = 1'b1;

    // R1: first timestamp comes from a counter started at zero at reset
    do_write(31, 32'h0000_00A5, 1, ts);
    exp_src(31, 1, 32'h0000_00A5, ts, "R1");
    wait_drain("R1");

    // R3 / R4 encodings for every size
    do_write(0, 32'h0000_0041, 1, ts);
    exp_src(0, 1, 32'h0000_0041, 0, "R3");
    wait_drain("R3");
    do_write(5, 32'h0000_BEEF, 2, ts);
    exp_src(5, 2, 32'h0000_BEEF, 0, "R4");
    wait_drain("R4");
    do_write(200, 32'h1234_5678, 3, ts);
    exp_src(200, 3, 32'h1234_5678, 0, "R3");
    wait_drain("R3");

    // R2: disabled port is dropped without stall
    try_write(6, 32'hDEAD_BEEF, 3, 1'b0, acc, ts);
    chk(acc == 1'b1, "R2", "wr_ready on disabled port", acc, 1);
    quiet(10, "R2");

    // R4: size code 00 discarded
    try_write(8, 32'h5555_5555, 0, 1'b0, acc, ts);
    chk(acc == 1'b1, "R4", "wr_ready for size 00", acc, 1);
    quiet(10, "R4");

    // R9 / R10: two timestamped writes with a gap
    do_write(31, 32'h0102_0304, 3, ts);
    exp_src(31, 3, 32'h0102_0304, ts, "R9");
    repeat (30) @(negedge clk);
    do_write(31, 32'h0000_7788, 2, ts1);
    exp_src(31, 2, 32'h0000_7788, ts1, "R10");
    wait_drain("R10");

    // R5..R8, R13: depth, stall, overflow, priority
    out_ready = 1'b0;
    do_write(3, 32'h0000_00A3, 1, ts);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      try_write(4, 32'h40 + i, 1, 1'b0, acc, ts);
      chk(acc == 1'b1, "R5", "accept within depth", acc, 1);
    end
    try_write(4, 32'h0000_00EE, 1, 1'b0, acc, ts);
    chk(acc == 1'b0, "R5", "wr_ready on full queue", acc, 0);
    try_write(4, 32'h0000_00EF, 1, 1'b1, acc, ts);
    chk(acc == 1'b1, "R6", "forced write accepted", acc, 1);
    try_write(4, 32'h0000_00F0, 1, 1'b1, acc, ts);
    chk(acc == 1'b1, "R6", "second forced write accepted", acc, 1);
    do_write(9, 32'h0000_9999, 2, ts);
    do_write(2, 32'h0000_0022, 1, ts);
    exp_src(3, 1, 32'h0000_00A3, 0, "R7");
    push_exp(8'h70, "R6");
    exp_src(2, 1, 32'h0000_0022, 0, "R8");
    for (int i = 0; i < 8; i++) exp_src(4, 1, 32'h40 + i, 0, "R13");
    exp_src(9, 2, 32'h0000_9999, 0, "R8");
    @(negedge clk);
    out_ready = 1'b1;
    wait_drain("R7");

    // R12: stream hold under stalls
    do_write(12, 32'hCAFE_F00D, 3, ts);
    exp_src(12, 3, 32'hCAFE_F00D, 0, "R12");
    prev_stall = 1'b0;
    prev_d = '0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      out_ready = (i % 3 == 2);
      #2;
      if (prev_stall)
        chk(out_valid && out_data == prev_d, "R12", "held byte", out_data, prev_d);
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
    end
    out_ready = 1'b1;
    wait_drain("R12");

    // R11: trace disabled
    trace_en = 1'b0;
    try_write(1, 32'h0000_0011, 1, 1'b0, acc, ts);
    chk(acc == 1'b1, "R11", "accept while trace off", acc, 1);
    quiet(10, "R11");
    trace_en = 1'b1;
    quiet(5, "R11");
    do_write(1, 32'h0000_0012, 1, ts);
    exp_src(1, 1, 32'h0000_0012, 0, "R11");
    wait_drain("R11");

    finish_run();
  end
endmodule